// File: doc/BRIEF.md
# Port-Mapped I/O Register Bank

This block gives a CPU a second address space for device registers. The space sits on the same address and data lines as main memory. The CPU raises a read-port or write-port strobe for an IN or OUT instruction. From those strobes the block derives a port-select level and a memory chip-select. Any cycle without a strobe leaves memory enabled. Only the low twelve address lines reach the bank. Port address 0x005 and memory address 0x000005 therefore never collide, because the select levels keep the two spaces apart.

Every register is 16 bits wide and has two access paths. The CPU path is one. The other is a peripheral path, which lets an external device read and write the same registers in any cycle. Both sides see registered read data one cycle after their read strobe. When both sides write the same register in the same cycle, the CPU write wins. A read of a register that is being written in the same cycle returns the contents before the write. The number of implemented registers is a parameter. Locations above it, up to 0xFFF, read as zero and discard writes.

Top module: `pio_regbank`

## Requirements
- R1: After reset every register holds zero, and both read-valid outputs are low with their data outputs at zero.
- R2: `port_sel` is high in exactly those cycles where `io_rd` or `io_wr` is high. It follows the strobes combinationally.
- R3: `mem_sel` is the complement of `port_sel`, so memory is disabled during every port access and enabled otherwise.
- R4: Only `cpu_addr[11:0]` selects a register. Bits 23..12 are ignored, so for example 0xABC005 and 0x000005 reach the same register.
- R5: A CPU write (`io_wr` high) stores `cpu_wdata` into the selected register at the rising edge. For example, writing 0x9A80 to port 0x28F leaves register 0x28F holding 0x9A80.
- R6: Port addresses at or above the parameter `DEPTH` read as 0x0000 on both sides, and writes to them change no register.
- R7: A CPU read is registered. `cpu_rdata_oe` is high in the cycle after a cycle with `io_rd` high, and in no other cycle. `cpu_rdata` is zero whenever `cpu_rdata_oe` is low.
- R8: The peripheral writes the register at `per_addr` on the rising edge when `per_we` is high. After `per_rd` it gets the contents on `per_rdata` one cycle later, with `per_rvalid` high for that cycle only.
- R9: The CPU and the peripheral may read the same register in the same cycle, and both get its contents.
- R10: One side may read a register while the other side writes a different register. The read returns the unchanged contents and the write takes effect.
- R11: If both sides write the same register in the same cycle, the register takes the CPU value. Writes by the two sides to different registers in the same cycle both take effect.
- R12: A read of a register that is written in the same cycle returns the contents from before the write, whichever side writes.
- R13: A cycle with neither strobe high is a memory cycle and changes no register, whatever is on `cpu_addr` and `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 24 | CPU address bus |
| cpu_wdata | input | 16 | CPU write data |
| io_rd | input | 1 | Read-port strobe (IN) |
| io_wr | input | 1 | Write-port strobe (OUT) |
| port_sel | output | 1 | Port space selected |
| mem_sel | output | 1 | Main memory chip-select |
| cpu_rdata | output | 16 | CPU read data, zero when not driven |
| cpu_rdata_oe | output | 1 | Drive enable for the CPU data bus |
| per_addr | input | 12 | Peripheral register address |
| per_we | input | 1 | Peripheral write strobe |
| per_wdata | input | 16 | Peripheral write data |
| per_rd | input | 1 | Peripheral read strobe |
| per_rdata | output | 16 | Peripheral read data |
| per_rvalid | output | 1 | Peripheral read data valid |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle, as an instruction issues either an IN or an OUT. They also assume that all inputs are settled before each rising edge. The bench drives every input on the falling edge and raises at most one CPU strobe per cycle. It still overlaps CPU and peripheral activity freely, to reach the same-register and different-register collisions. The full implemented range is swept on both sides, with the upper address bits varied and with values computed arithmetically from the index.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned CPU_AW  = 24;
  localparam int unsigned PORT_AW = 12;
  localparam int unsigned DATA_W  = 16;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [PORT_AW-1:0] paddr_t;
endpackage

// File: rtl/pio_select.sv
module pio_select (
  input  logic io_rd,
  input  logic io_wr,
  output logic port_sel,
  output logic mem_sel
);
  always_comb begin
    port_sel = io_rd | io_wr;
    mem_sel  = ~port_sel;
  end
endmodule

// File: rtl/pio_addr_dec.sv
module pio_addr_dec #(
  parameter int unsigned PORT_AW = 12,
  parameter int unsigned DEPTH   = 1024,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic [PORT_AW-1:0] addr,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    hit = (32'(addr) < DEPTH);
    idx = addr[IDX_W-1:0];
  end
endmodule

// File: rtl/pio_store.sv
module pio_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_we,
  input  logic [IDX_W-1:0]               cpu_idx,
  input  logic [DATA_W-1:0]              cpu_wdata,
  input  logic                           per_we,
  input  logic [IDX_W-1:0]               per_idx,
  input  logic [DATA_W-1:0]              per_wdata,
  output logic [DEPTH-1:0][DATA_W-1:0]   q
);
  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_ent
    logic              cpu_hit;
    logic              per_hit;
    logic              ld_en;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      cpu_hit = cpu_we && (cpu_idx == IDX_W'(i));
      per_hit = per_we && (per_idx == IDX_W'(i));
      ld_en   = cpu_hit | per_hit;
      // CPU side has priority on a same-register collision
      nxt     = cpu_hit ? cpu_wdata : per_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= '0;
      end else if (ld_en) begin
        q[i] <= nxt;
      end
    end
  end
endmodule

// File: rtl/pio_read_port.sv
module pio_read_port #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic                         hit,
  input  logic [IDX_W-1:0]             idx,
  input  logic [DEPTH-1:0][DATA_W-1:0] q,
  output logic [DATA_W-1:0]            rdata,
  output logic                         rvalid
);
  logic [DATA_W-1:0] data_d, data_q;
  logic              vld_d,  vld_q;

  always_comb begin
    data_d = '0;
    vld_d  = 1'b0;
    if (rd_en) begin
      vld_d  = 1'b1;
      data_d = hit ? q[idx] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign rdata  = data_q;
  assign rvalid = vld_q;
endmodule

// File: rtl/pio_regbank.sv
module pio_regbank
  import pio_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              port_sel,
  output logic              mem_sel,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  input  logic [PORT_AW-1:0] per_addr,
  input  logic              per_we,
  input  logic [DATA_W-1:0] per_wdata,
  input  logic              per_rd,
  output logic [DATA_W-1:0] per_rdata,
  output logic              per_rvalid
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  // upper CPU address lines take no part in port decode
  logic unused_addr_hi;
  assign unused_addr_hi = ^cpu_addr[CPU_AW-1:PORT_AW];

  pio_select u_sel (
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .port_sel (port_sel),
    .mem_sel  (mem_sel)
  );

  logic             cpu_hit, per_hit;
  logic [IDX_W-1:0] cpu_idx, per_idx;

  pio_addr_dec #(.PORT_AW(PORT_AW), .DEPTH(DEPTH)) u_cpu_dec (
    .addr (cpu_addr[PORT_AW-1:0]),
    .hit  (cpu_hit),
    .idx  (cpu_idx)
  );

  pio_addr_dec #(.PORT_AW(PORT_AW), .DEPTH(DEPTH)) u_per_dec (
    .addr (per_addr),
    .hit  (per_hit),
    .idx  (per_idx)
  );

  logic cpu_we_g, per_we_g;
  always_comb begin
    cpu_we_g = io_wr  && cpu_hit;
    per_we_g = per_we && per_hit;
  end

  logic [DEPTH-1:0][DATA_W-1:0] regs;

  pio_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cpu_we    (cpu_we_g),
    .cpu_idx   (cpu_idx),
    .cpu_wdata (cpu_wdata),
    .per_we    (per_we_g),
    .per_idx   (per_idx),
    .per_wdata (per_wdata),
    .q         (regs)
  );

  pio_read_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_cpu_rd (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .rd_en  (io_rd),
    .hit    (cpu_hit),
    .idx    (cpu_idx),
    .q      (regs),
    .rdata  (cpu_rdata),
    .rvalid (cpu_rdata_oe)
  );

  pio_read_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_per_rd (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .rd_en  (per_rd),
    .hit    (per_hit),
    .idx    (per_idx),
    .q      (regs),
    .rdata  (per_rdata),
    .rvalid (per_rvalid)
  );
endmodule

// File: rtl/pio_regbank_chk.sv
module pio_regbank_chk #(
  parameter int unsigned DEPTH   = 1024,
  parameter int unsigned PORT_AW = 12,
  parameter int unsigned CPU_AW  = 24,
  parameter int unsigned DATA_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              port_sel,
  input logic              mem_sel,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_rdata_oe,
  input logic              per_rd,
  input logic [PORT_AW-1:0] per_addr,
  input logic [DATA_W-1:0] per_rdata,
  input logic              per_rvalid
);
  AST_STROBE_SELECTS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> (port_sel && !mem_sel)); // R2
  AST_IDLE_SELECTS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd || io_wr) |-> (mem_sel && !port_sel)); // R3
  AST_CPU_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> cpu_rdata_oe); // R7
  AST_CPU_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> (!cpu_rdata_oe && cpu_rdata == '0)); // R7
  AST_CPU_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (32'(cpu_addr[PORT_AW-1:0]) >= DEPTH)) |=> (cpu_rdata == '0)); // R6
  AST_PER_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rd && (32'(per_addr) >= DEPTH)) |=> (per_rvalid && per_rdata == '0)); // R6
  AST_PER_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    per_rd |=> per_rvalid); // R8
  AST_PER_VALID_ONLY_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !per_rd |=> !per_rvalid); // R8
endmodule

bind pio_regbank pio_regbank_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_s_n),
  .cpu_addr     (cpu_addr),
  .io_rd        (io_rd),
  .io_wr        (io_wr),
  .port_sel     (port_sel),
  .mem_sel      (mem_sel),
  .cpu_rdata    (cpu_rdata),
  .cpu_rdata_oe (cpu_rdata_oe),
  .per_rd       (per_rd),
  .per_addr     (per_addr),
  .per_rdata    (per_rdata),
  .per_rvalid   (per_rvalid)
);

// File: tb/pio_regbank_bench.sv
`timescale 1ns/1ps
module pio_regbank_bench;
  localparam int N = 1024;

  logic        clk;
  logic        rst_n;
  logic [23:0] cpu_addr;
  logic [15:0] cpu_wdata;
  logic        io_rd, io_wr;
  logic        port_sel, mem_sel;
  logic [15:0] cpu_rdata;
  logic        cpu_rdata_oe;
  logic [11:0] per_addr;
  logic        per_we;
  logic [15:0] per_wdata;
  logic        per_rd;
  logic [15:0] per_rdata;
  logic        per_rvalid;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [N];

  pio_regbank #(.DEPTH(N)) u_pio_regbank (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .port_sel(port_sel), .mem_sel(mem_sel),
    .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe), .per_addr(per_addr),
    .per_we(per_we), .per_wdata(per_wdata), .per_rd(per_rd),
    .per_rdata(per_rdata), .per_rvalid(per_rvalid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [15:0] pat_a(int i);
    return 16'((i * 37 + 16'h1234) ^ 16'h5A5A);
  endfunction
  function automatic logic [15:0] pat_b(int i);
    return 16'((i * 113) ^ 16'hC3C3);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic store(logic [11:0] a, logic [15:0] d);
    if (int'(a) < N) model[int'(a)] = d;
  endtask

  function automatic logic [15:0] peek(logic [11:0] a);
    return (int'(a) < N) ? model[int'(a)] : 16'h0000;
  endfunction

  // all tasks start and end just after a falling edge
  task automatic cpu_wr(logic [23:0] a, logic [15:0] d);
    io_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    store(a[11:0], d);
  endtask

  task automatic per_wr(logic [11:0] a, logic [15:0] d);
    per_we = 1'b1; per_addr = a; per_wdata = d;
    @(negedge clk);
    per_we = 1'b0;
    store(a, d);
  endtask

  task automatic cpu_rd(string req, logic [23:0] a);
    logic [15:0] e;
    e = peek(a[11:0]);
    io_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    chk(req, cpu_rdata, e);
    chk({req, " oe"}, 16'(cpu_rdata_oe), 16'h1);
  endtask

  task automatic per_rdc(string req, logic [11:0] a);
    logic [15:0] e;
    e = peek(a);
    per_rd = 1'b1; per_addr = a;
    @(negedge clk);
    per_rd = 1'b0;
    chk(req, per_rdata, e);
    chk({req, " valid"}, 16'(per_rvalid), 16'h1);
  endtask

  initial begin
    rst_n = 1'b0;
    io_rd = 1'b0; io_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    per_we = 1'b0; per_rd = 1'b0; per_addr = '0; per_wdata = '0;
    for (int i = 0; i < N; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 oe", 16'(cpu_rdata_oe), 16'h0);
    chk("R1 cpu data", cpu_rdata, 16'h0);
    chk("R1 per valid", 16'(per_rvalid), 16'h0);
    cpu_rd("R1 reg0", 24'h000000);
    per_rdc("R1 reg top", 12'(N - 1));

    // R5 OUT example
    cpu_wr(24'h00028F, 16'h9A80);
    cpu_rd("R5 port 0x28F", 24'h00028F);

    // R5 R4 sweep: CPU writes with varied upper bits, peripheral reads back
    for (int i = 0; i < N; i++) cpu_wr({12'(i * 5 + 1), 12'(i)}, pat_a(i));
    for (int i = 0; i < N; i++) per_rdc("R5 sweep", 12'(i));

    // R8 R4 sweep: peripheral writes odd registers, CPU reads through aliases
    for (int i = 1; i < N; i += 2) per_wr(12'(i), pat_b(i));
    for (int i = 0; i < N; i++) cpu_rd("R8 sweep R4 alias", {12'(12'hFFF - i), 12'(i)});
    chk("R4 alias value", peek(12'h005), pat_b(5));

    // R6 out of range
    cpu_wr(24'h000400, 16'hBEEF);
    cpu_wr(24'h123FFF, 16'h1111);
    per_wr(12'h800, 16'h2222);
    cpu_rd("R6 cpu 0x400", 24'h000400);
    per_rdc("R6 per 0xFFF", 12'hFFF);
    cpu_rd("R6 reg0 untouched", 24'h000000);
    per_rdc("R6 reg 0x3FF untouched", 12'h3FF);

    // R7 bus released the cycle after the read
    @(negedge clk);
    chk("R7 oe low", 16'(cpu_rdata_oe), 16'h0);
    chk("R7 data zero", cpu_rdata, 16'h0);

    // R2 R3 select levels follow strobes
    io_wr = 1'b1; cpu_addr = 24'h000003; cpu_wdata = 16'h0F0F;
    #1;
    chk("R2 port_sel on write", 16'(port_sel), 16'h1);
    chk("R3 mem_sel on write", 16'(mem_sel), 16'h0);
    @(negedge clk);
    io_wr = 1'b0; store(12'h003, 16'h0F0F);
    io_rd = 1'b1;
    #1;
    chk("R2 port_sel on read", 16'(port_sel), 16'h1);
    chk("R3 mem_sel on read", 16'(mem_sel), 16'h0);
    @(negedge clk);
    io_rd = 1'b0;
    #1;
    chk("R2 port_sel idle", 16'(port_sel), 16'h0);
    chk("R3 mem_sel idle", 16'(mem_sel), 16'h1);

    // R13 memory cycle on a port-range address
    cpu_addr = 24'h000007; cpu_wdata = 16'hFFFF;
    repeat (2) @(negedge clk);
    cpu_rd("R13 reg7 unchanged", 24'h000007);

    // R9 both sides read one register
    io_rd = 1'b1; cpu_addr = 24'h000100; per_rd = 1'b1; per_addr = 12'h100;
    @(negedge clk);
    io_rd = 1'b0; per_rd = 1'b0;
    chk("R9 cpu", cpu_rdata, peek(12'h100));
    chk("R9 per", per_rdata, peek(12'h100));

    // R10 read one register while the other side writes another
    io_rd = 1'b1; cpu_addr = 24'h000010; per_we = 1'b1; per_addr = 12'h011; per_wdata = 16'h7777;
    @(negedge clk);
    io_rd = 1'b0; per_we = 1'b0;
    chk("R10 cpu read", cpu_rdata, peek(12'h010));
    store(12'h011, 16'h7777);
    cpu_rd("R10 write landed", 24'h000011);

    // R11 same-register write collision, then different registers
    io_wr = 1'b1; cpu_addr = 24'h000020; cpu_wdata = 16'hC0DE;
    per_we = 1'b1; per_addr = 12'h020; per_wdata = 16'hDEAD;
    @(negedge clk);
    io_wr = 1'b0; per_we = 1'b0; store(12'h020, 16'hC0DE);
    cpu_rd("R11 cpu wins", 24'h000020);
    io_wr = 1'b1; cpu_addr = 24'h000021; cpu_wdata = 16'hAAAA;
    per_we = 1'b1; per_addr = 12'h022; per_wdata = 16'h5555;
    @(negedge clk);
    io_wr = 1'b0; per_we = 1'b0;
    store(12'h021, 16'hAAAA); store(12'h022, 16'h5555);
    per_rdc("R11 cpu write other reg", 12'h021);
    cpu_rd("R11 per write other reg", 24'h000022);

    // R12 read-before-write in both directions
    io_wr = 1'b1; cpu_addr = 24'h000030; cpu_wdata = 16'h3030;
    per_rd = 1'b1; per_addr = 12'h030;
    @(negedge clk);
    io_wr = 1'b0; per_rd = 1'b0;
    chk("R12 per sees old", per_rdata, peek(12'h030));
    store(12'h030, 16'h3030);
    io_rd = 1'b1; cpu_addr = 24'h000031;
    per_we = 1'b1; per_addr = 12'h031; per_wdata = 16'h3131;
    @(negedge clk);
    io_rd = 1'b0; per_we = 1'b0;
    chk("R12 cpu sees old", cpu_rdata, peek(12'h031));
    store(12'h031, 16'h3131);
    per_rdc("R12 new value", 12'h030);
    cpu_rd("R12 new value", 24'h000031);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule